// File: doc/BRIEF.md
# Serial Character Receiver with Sticky Line-Error Flags

This block recovers asynchronous serial characters from a single input line. A sample enable pulses sixteen times per bit period, and the receiver uses it to hunt for a falling edge, confirm the start bit halfway through its period, and take every later bit at its centre. Character length and parity handling are chosen at run time with the same field encodings the companion transmitter uses. Each finished character goes into a holding register and raises a ready flag that stays up until the consumer pulses a read strobe.

Errors on the line are kept in sticky flags: parity mismatch, bad stop bit, overrun of an unread character, and break (line held low for a whole character). A clear-errors command drops the parity, framing and overrun flags and leaves the data flags as they are. An idle time-out can be re-armed by command. It starts counting after the next character and fires once the line has stayed idle for a programmed number of bit periods.

Top module: `uart_rx_status`

## Requirements
- R1: Data bits are taken least significant bit first. The character length is set by `charLen` (00 = 5, 01 = 6, 10 = 7, 11 = 8 bits). A finished character appears right-aligned on `rxData` with zeros above its length, and `rxReady` goes to 1.
- R2: `rxReady` stays at 1 until a `readStrobe` pulse clears it. Nothing else clears it except `rxResetCmd` and the asynchronous reset.
- R3: When a character finishes while `rxReady` is already 1 and no read arrives in that cycle, `overrunErr` goes to 1 and `rxData` takes the new character.
- R4: `clrErrCmd` clears `parityErr`, `frameErr` and `overrunErr`. It leaves `rxReady`, `rxData` and `breakSeen` unchanged.
- R5: Parity follows `parityMode`. In mode 00 (checked) a bit follows the data: `parityType` 0 means even and 1 means odd. In mode 01 (forced) the bit must equal `parityType`. Mode 10 has no parity bit. In mode 11 (multidrop) the bit is present but not checked. A mismatch sets the sticky `parityErr`.
- R6: In multidrop mode the received parity-position bit is presented on `rxAddrBit` together with the character. In every other mode `rxAddrBit` is 0.
- R7: A low stop bit on a character that is not a break sets `frameErr`. The character is still loaded and flagged ready.
- R8: When every sampled bit of a frame is low, the stop bit included, `breakSeen` goes to 1. In that case `frameErr` is not set, no character is loaded, and the receiver waits for the line to return high before it hunts again.
- R9: A low pulse that is gone by the eighth sample tick after the falling edge is dropped as a glitch. No character and no flag results.
- R10: While `rxEnable` is 0 the line is ignored and no character or flag is produced.
- R11: `rxResetCmd` and the asynchronous reset clear `rxReady`, `rxData`, every error flag, `rxAddrBit` and `timeoutFlag`, and return the receiver to start-bit hunting.
- R12: `restartToCmd` clears `timeoutFlag` and arms the time-out. After the next character finishes, `timeoutFlag` goes to 1 once the line has been idle for `toBitTimes` bit periods (16 sample ticks each) with no new start bit. A count of 0 disables it, and it never counts unless armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleTick | input | 1 | Sample enable, 16 pulses per bit period |
| rxLine | input | 1 | Serial input line, idle high |
| rxEnable | input | 1 | Receiver enable |
| rxResetCmd | input | 1 | Receive logic reset pulse |
| clrErrCmd | input | 1 | Clear parity, framing and overrun flags |
| restartToCmd | input | 1 | Re-arm the idle time-out |
| readStrobe | input | 1 | Consumer read of the holding register |
| charLen | input | 2 | Character length code |
| parityMode | input | 2 | Parity mode code |
| parityType | input | 1 | Odd/even select or forced parity value |
| toBitTimes | input | 8 | Time-out length in bit periods |
| rxData | output | 8 | Holding register |
| rxReady | output | 1 | Holding register full |
| rxAddrBit | output | 1 | Multidrop address marker |
| parityErr | output | 1 | Sticky parity error |
| frameErr | output | 1 | Sticky framing error |
| overrunErr | output | 1 | Sticky overrun error |
| breakSeen | output | 1 | Sticky break indication |
| timeoutFlag | output | 1 | Idle time-out reached |

## Verification
The bench drives an all-low frame. A receiver that mistook it for a bad stop bit would raise the framing flag, or would load a zero character, or would restart on the still-low line and lose the next real character. It checks that clearing errors does not disturb a pending character or the break flag, and that two unread characters raise overrun while the newer one is kept. Short low pulses are used to catch a start detector that never confirms at the half bit. The time-out is sampled half a bit before and half a bit after its programmed length, so a counter that is off by a whole bit period, or that starts before the first character, shows up.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_REARM
  } rxState_t;

  typedef struct packed {
    logic frameStart;
    logic takeData;
    logic takePar;
    logic charDone;
    logic lineBit;
  } rxStrobe_t;

  localparam int MAX_BITS = 8;

  localparam logic [1:0] PAR_CHECKED = 2'b00;
  localparam logic [1:0] PAR_FORCED  = 2'b01;
  localparam logic [1:0] PAR_NONE    = 2'b10;
  localparam logic [1:0] PAR_MDROP   = 2'b11;

endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OVS  = 16,
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sampleTick,
  input  logic            rxLine,
  input  logic            rxEnable,
  input  logic            rxResetCmd,
  input  logic            restartToCmd,
  input  logic [1:0]      charLen,
  input  logic [1:0]      parityMode,
  input  logic [TO_W-1:0] toBitTimes,
  output rxStrobe_t       strobe,
  output logic            timeoutFlag
);

  localparam int PH_W = $clog2(OVS);
  localparam logic [PH_W-1:0] HALF = PH_W'(OVS / 2 - 1);
  localparam logic [PH_W-1:0] FULL = PH_W'(OVS - 1);

  logic [1:0]      syncQ;
  logic            lineS;
  rxState_t        state, stateNext;
  logic [PH_W-1:0] phase;
  logic [2:0]      bitIdx;
  logic [2:0]      lastBit;
  logic            hasPar;
  logic            phaseHit;
  logic            active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], rxLine};
  end
  assign lineS = syncQ[1];

  assign lastBit  = 3'(3'd4 + 3'(charLen));
  assign hasPar   = (parityMode != PAR_NONE);
  assign phaseHit = sampleTick && (phase == ((state == ST_START) ? HALF : FULL));
  assign active   = rxEnable && !rxResetCmd;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    strobe.lineBit = lineS;
    if (active) begin
      case (state)
        ST_IDLE: if (sampleTick && !lineS) begin
          stateNext = ST_START;
          strobe.frameStart = 1'b1;
        end
        ST_START: if (phaseHit) stateNext = lineS ? ST_IDLE : ST_DATA;
        ST_DATA: if (phaseHit) begin
          strobe.takeData = 1'b1;
          if (bitIdx == lastBit) stateNext = hasPar ? ST_PAR : ST_STOP;
        end
        ST_PAR: if (phaseHit) begin
          strobe.takePar = 1'b1;
          stateNext = ST_STOP;
        end
        ST_STOP: if (phaseHit) begin
          strobe.charDone = 1'b1;
          stateNext = ST_REARM;
        end
        ST_REARM: if (sampleTick && lineS) stateNext = ST_IDLE;
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      phase  <= '0;
      bitIdx <= '0;
    end else if (!active) begin
      state  <= ST_IDLE;
      phase  <= '0;
      bitIdx <= '0;
    end else begin
      state <= stateNext;
      if (sampleTick) begin
        if (phaseHit || state == ST_IDLE || state == ST_REARM) phase <= '0;
        else phase <= phase + 1'b1;
      end
      if (state != ST_DATA) bitIdx <= '0;
      else if (phaseHit)    bitIdx <= bitIdx + 1'b1;
    end
  end

  // Idle time-out: armed by restart, runs after the next character.
  logic            toArmed, toActive;
  logic [PH_W-1:0] toTick;
  logic [TO_W-1:0] toBits;
  logic            lineQuiet;

  assign lineQuiet = (state == ST_IDLE) || (state == ST_REARM);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeoutFlag <= 1'b0;
      toArmed     <= 1'b0;
      toActive    <= 1'b0;
      toTick      <= '0;
      toBits      <= '0;
    end else if (rxResetCmd || restartToCmd) begin
      timeoutFlag <= 1'b0;
      toArmed     <= restartToCmd && !rxResetCmd;
      toActive    <= 1'b0;
      toTick      <= '0;
      toBits      <= '0;
    end else if (strobe.charDone && (toArmed || toActive)) begin
      toArmed  <= 1'b0;
      toActive <= 1'b1;
      toTick   <= '0;
      toBits   <= '0;
    end else if (toActive && !lineQuiet) begin
      toTick <= '0;
      toBits <= '0;
    end else if (toActive && sampleTick && toBitTimes != '0) begin
      if (toTick == FULL) begin
        toTick <= '0;
        if (toBits + TO_W'(1) == toBitTimes) begin
          timeoutFlag <= 1'b1;
          toActive    <= 1'b0;
        end else begin
          toBits <= toBits + TO_W'(1);
        end
      end else begin
        toTick <= toTick + 1'b1;
      end
    end
  end

  // R10: a disabled receiver sits in the hunting state
  assert_disabled_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (state == ST_IDLE));

  // R12: a restart always leaves the time-out flag low
  assert_restart_clears_R12: assert property (@(posedge clk) disable iff (!rstN)
    restartToCmd |=> !timeoutFlag);

  // R9: a start that is high at the half-bit check never yields data strobes
  assert_glitch_drop_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && phaseHit && lineS) |=> !strobe.takeData);

endmodule

// File: rtl/uart_rx_datapath.sv
module uart_rx_datapath
  import uart_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  rxStrobe_t           strobe,
  input  logic                rxResetCmd,
  input  logic                clrErrCmd,
  input  logic                readStrobe,
  input  logic [1:0]          charLen,
  input  logic [1:0]          parityMode,
  input  logic                parityType,
  output logic [MAX_BITS-1:0] rxData,
  output logic                rxReady,
  output logic                rxAddrBit,
  output logic                parityErr,
  output logic                frameErr,
  output logic                overrunErr,
  output logic                breakSeen
);

  logic [MAX_BITS-1:0] shiftReg;
  logic [MAX_BITS-1:0] alignedData;
  logic                parBitQ;
  logic                allLow;
  logic                parBad;
  logic                isBreak;
  logic                goodChar;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBitQ  <= 1'b0;
      allLow   <= 1'b0;
    end else if (rxResetCmd) begin
      shiftReg <= '0;
      parBitQ  <= 1'b0;
      allLow   <= 1'b0;
    end else begin
      if (strobe.frameStart) begin
        shiftReg <= '0;
        parBitQ  <= 1'b0;
        allLow   <= 1'b1;
      end
      if (strobe.takeData) begin
        shiftReg <= {strobe.lineBit, shiftReg[MAX_BITS-1:1]};
        allLow   <= allLow & ~strobe.lineBit;
      end
      if (strobe.takePar) begin
        parBitQ <= strobe.lineBit;
        allLow  <= allLow & ~strobe.lineBit;
      end
    end
  end

  assign alignedData = shiftReg >> (2'd3 - charLen);

  always_comb begin
    case (parityMode)
      PAR_CHECKED: parBad = ((^alignedData) ^ parBitQ) != parityType;
      PAR_FORCED:  parBad = parBitQ != parityType;
      default:     parBad = 1'b0;
    endcase
  end

  assign isBreak  = allLow && !strobe.lineBit;
  assign goodChar = strobe.charDone && !isBreak;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData     <= '0;
      rxReady    <= 1'b0;
      rxAddrBit  <= 1'b0;
      parityErr  <= 1'b0;
      frameErr   <= 1'b0;
      overrunErr <= 1'b0;
      breakSeen  <= 1'b0;
    end else if (rxResetCmd) begin
      rxData     <= '0;
      rxReady    <= 1'b0;
      rxAddrBit  <= 1'b0;
      parityErr  <= 1'b0;
      frameErr   <= 1'b0;
      overrunErr <= 1'b0;
      breakSeen  <= 1'b0;
    end else begin
      if (goodChar) begin
        rxData    <= alignedData;
        rxAddrBit <= (parityMode == PAR_MDROP) ? parBitQ : 1'b0;
      end

      if (goodChar)        rxReady <= 1'b1;
      else if (readStrobe) rxReady <= 1'b0;

      if (goodChar && rxReady && !readStrobe) overrunErr <= 1'b1;
      else if (clrErrCmd)                     overrunErr <= 1'b0;

      if (goodChar && parBad) parityErr <= 1'b1;
      else if (clrErrCmd)     parityErr <= 1'b0;

      if (goodChar && !strobe.lineBit) frameErr <= 1'b1;
      else if (clrErrCmd)              frameErr <= 1'b0;

      if (strobe.charDone && isBreak) breakSeen <= 1'b1;
    end
  end

  // R2: a read with no new character empties the holding register
  assert_read_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    (readStrobe && !strobe.charDone) |=> !rxReady);

  // R3: a character landing on an unread one raises overrun
  assert_overrun_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.charDone && !isBreak && rxReady && !readStrobe && !rxResetCmd) |=> overrunErr);

  // R4: clearing errors leaves the data side untouched
  assert_clr_keeps_data_R4: assert property (@(posedge clk) disable iff (!rstN)
    (clrErrCmd && !strobe.charDone && !readStrobe && !rxResetCmd) |=>
      (!parityErr && !frameErr && !overrunErr && $stable(rxReady) && $stable(rxData) && $stable(breakSeen)));

  // R8: a break never raises the framing flag
  assert_break_no_frame_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(breakSeen) |-> !$rose(frameErr));

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int OVS  = 16,
  parameter int TO_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleTick,
  input  logic                rxLine,
  input  logic                rxEnable,
  input  logic                rxResetCmd,
  input  logic                clrErrCmd,
  input  logic                restartToCmd,
  input  logic                readStrobe,
  input  logic [1:0]          charLen,
  input  logic [1:0]          parityMode,
  input  logic                parityType,
  input  logic [TO_W-1:0]     toBitTimes,
  output logic [MAX_BITS-1:0] rxData,
  output logic                rxReady,
  output logic                rxAddrBit,
  output logic                parityErr,
  output logic                frameErr,
  output logic                overrunErr,
  output logic                breakSeen,
  output logic                timeoutFlag
);

  rxStrobe_t strobe;

  uart_rx_ctrl #(.OVS(OVS), .TO_W(TO_W)) ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .sampleTick   (sampleTick),
    .rxLine       (rxLine),
    .rxEnable     (rxEnable),
    .rxResetCmd   (rxResetCmd),
    .restartToCmd (restartToCmd),
    .charLen      (charLen),
    .parityMode   (parityMode),
    .toBitTimes   (toBitTimes),
    .strobe       (strobe),
    .timeoutFlag  (timeoutFlag)
  );

  uart_rx_datapath dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .rxResetCmd (rxResetCmd),
    .clrErrCmd  (clrErrCmd),
    .readStrobe (readStrobe),
    .charLen    (charLen),
    .parityMode (parityMode),
    .parityType (parityType),
    .rxData     (rxData),
    .rxReady    (rxReady),
    .rxAddrBit  (rxAddrBit),
    .parityErr  (parityErr),
    .frameErr   (frameErr),
    .overrunErr (overrunErr),
    .breakSeen  (breakSeen)
  );

endmodule

// File: tb/uart_rx_status_test.sv
module uart_rx_status_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleTick = 1'b0;
  logic rxLine = 1'b1;
  logic rxEnable = 1'b1;
  logic rxResetCmd = 1'b0;
  logic clrErrCmd = 1'b0;
  logic restartToCmd = 1'b0;
  logic readStrobe = 1'b0;
  logic [1:0] charLen = 2'b11;
  logic [1:0] parityMode = 2'b10;
  logic parityType = 1'b0;
  logic [7:0] toBitTimes = 8'd4;
  logic [7:0] rxData;
  logic rxReady, rxAddrBit, parityErr, frameErr, overrunErr, breakSeen, timeoutFlag;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int tickDiv = 0;

  // expected state
  logic [7:0] expData = 8'h00;
  logic expReady = 0, expAddr = 0, expPE = 0, expFE = 0, expOE = 0, expBrk = 0, expTo = 0;

  uart_rx_status uut (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .rxEnable(rxEnable), .rxResetCmd(rxResetCmd), .clrErrCmd(clrErrCmd),
    .restartToCmd(restartToCmd), .readStrobe(readStrobe), .charLen(charLen),
    .parityMode(parityMode), .parityType(parityType), .toBitTimes(toBitTimes),
    .rxData(rxData), .rxReady(rxReady), .rxAddrBit(rxAddrBit), .parityErr(parityErr),
    .frameErr(frameErr), .overrunErr(overrunErr), .breakSeen(breakSeen),
    .timeoutFlag(timeoutFlag)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    tickDiv = (tickDiv + 1) % 4;
    sampleTick = (tickDiv == 0);
  end

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    chk(req, "rxData", rxData, expData);
    chk(req, "rxReady", {7'b0, rxReady}, {7'b0, expReady});
    chk(req, "rxAddrBit", {7'b0, rxAddrBit}, {7'b0, expAddr});
    chk(req, "parityErr", {7'b0, parityErr}, {7'b0, expPE});
    chk(req, "frameErr", {7'b0, frameErr}, {7'b0, expFE});
    chk(req, "overrunErr", {7'b0, overrunErr}, {7'b0, expOE});
    chk(req, "breakSeen", {7'b0, breakSeen}, {7'b0, expBrk});
    chk(req, "timeoutFlag", {7'b0, timeoutFlag}, {7'b0, expTo});
  endtask

  task automatic sendBit(input logic v);
    rxLine = v;
    repeat (64) @(negedge clk);
  endtask

  function automatic logic [7:0] lenMask();
    return 8'hFF >> (3 - int'(charLen));
  endfunction

  function automatic logic goodPar(input logic [7:0] d);
    if (parityMode == 2'b00) return (^(d & lenMask())) ^ parityType;
    return parityType;
  endfunction

  // idle bit, start, data LSB first, optional parity, one stop bit
  task automatic sendFrame(input logic [7:0] d, input logic pbit, input logic stopLvl);
    int len = 5 + int'(charLen);
    logic [7:0] md = d & lenMask();
    logic brk;
    sendBit(1'b1);
    sendBit(1'b0);
    for (int i = 0; i < len; i++) sendBit(d[i]);
    if (parityMode != 2'b10) sendBit(pbit);
    sendBit(stopLvl);
    if (rxEnable) begin
      brk = (md == 8'h00) && (parityMode == 2'b10 || pbit == 1'b0) && !stopLvl;
      if (brk) expBrk = 1;
      else begin
        if (expReady) expOE = 1;
        expReady = 1;
        expData = md;
        expAddr = (parityMode == 2'b11) ? pbit : 1'b0;
        if (!stopLvl) expFE = 1;
        if (parityMode == 2'b00 && (((^md) ^ pbit) != parityType)) expPE = 1;
        if (parityMode == 2'b01 && pbit != parityType) expPE = 1;
      end
    end
  endtask

  task automatic doRead();
    readStrobe = 1'b1; @(negedge clk); readStrobe = 1'b0; @(negedge clk);
    expReady = 0;
  endtask

  task automatic doClr();
    clrErrCmd = 1'b1; @(negedge clk); clrErrCmd = 1'b0; @(negedge clk);
    expPE = 0; expFE = 0; expOE = 0;
  endtask

  task automatic doRestart();
    restartToCmd = 1'b1; @(negedge clk); restartToCmd = 1'b0; @(negedge clk);
    expTo = 0;
  endtask

  task automatic doRxReset();
    rxResetCmd = 1'b1; @(negedge clk); rxResetCmd = 1'b0; @(negedge clk);
    expData = 0; expReady = 0; expAddr = 0; expPE = 0; expFE = 0; expOE = 0; expBrk = 0; expTo = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish (R1 flow) actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    checkAll("R11 reset state");

    // R1: 8-bit character, no parity
    sendFrame(8'hA5, 1'b0, 1'b1);
    checkAll("R1 8-bit char");

    // R2: ready holds, then read clears
    repeat (128) @(negedge clk);
    checkAll("R2 ready held");
    doRead();
    checkAll("R2 read clears");

    // R3: overrun keeps newest data
    sendFrame(8'h3C, 1'b0, 1'b1);
    sendFrame(8'hC3, 1'b0, 1'b1);
    checkAll("R3 overrun");

    // R4: clear keeps data side
    doClr();
    checkAll("R4 clear errors");
    doRead();

    // R5: checked even parity, 7-bit
    charLen = 2'b10; parityMode = 2'b00; parityType = 1'b0;
    sendFrame(8'h55, goodPar(8'h55), 1'b1);
    checkAll("R5 even ok");
    doRead();
    sendFrame(8'h2A, ~goodPar(8'h2A), 1'b1);
    checkAll("R5 even bad");
    doClr(); doRead();
    parityType = 1'b1;
    sendFrame(8'h2B, goodPar(8'h2B), 1'b1);
    checkAll("R5 odd ok");
    doRead();
    parityMode = 2'b01;
    sendFrame(8'h11, 1'b0, 1'b1);
    checkAll("R5 forced mismatch");
    doClr(); doRead();

    // R6: multidrop address marker, never a parity error
    parityMode = 2'b11;
    sendFrame(8'h12, 1'b1, 1'b1);
    checkAll("R6 addr set");
    doRead();
    sendFrame(8'h13, 1'b0, 1'b1);
    checkAll("R6 addr clear");
    doRead();

    // R1: 5-bit character, upper bits zero
    charLen = 2'b00; parityMode = 2'b10;
    sendFrame(8'hF5, 1'b0, 1'b1);
    checkAll("R1 5-bit char");
    doRead();

    // R7: low stop bit
    charLen = 2'b11;
    sendFrame(8'h81, 1'b0, 1'b0);
    checkAll("R7 framing");
    doClr(); doRead();

    // R8: break, then recovery
    sendFrame(8'h00, 1'b0, 1'b0);
    checkAll("R8 break");
    sendBit(1'b1);
    sendFrame(8'h66, 1'b0, 1'b1);
    checkAll("R8 after break");
    doRead();
    doClr();
    checkAll("R4 break kept");

    // R9: glitch shorter than half a bit
    sendBit(1'b1);
    rxLine = 1'b0;
    repeat (12) @(negedge clk);
    sendBit(1'b1);
    sendBit(1'b1);
    checkAll("R9 glitch");

    // R10: disabled receiver
    rxEnable = 1'b0;
    sendFrame(8'h3C, 1'b0, 1'b1);
    rxEnable = 1'b1;
    checkAll("R10 disabled");

    // R12: idle time-out of 4 bit periods
    doRestart();
    checkAll("R12 armed");
    sendFrame(8'h11, 1'b0, 1'b1);
    doRead();
    repeat (3 * 64 - 4) @(negedge clk);
    checkAll("R12 before period");
    repeat (64) @(negedge clk);
    expTo = 1;
    checkAll("R12 expired");
    doRestart();
    checkAll("R12 restart");

    // R11: receive reset
    sendFrame(8'h77, 1'b0, 1'b0);
    checkAll("R11 pre-reset");
    doRxReset();
    checkAll("R11 rx reset");

    summary();
  end

endmodule